// File: doc/BRIEF.md
# Supply Fault Routing and Masking

This block sits behind the comparators of a six-rail voltage supervisor. Every rail gives one over-voltage flag and one under-voltage flag. Two general-purpose input pins give two more signals. Each of these pins is set to one of four roles: auxiliary comparator, margin input, under-voltage disable input or manual reset. Flags that are not masked become conditions. A per-output mapping matrix chooses which conditions drive each of three GPIO outputs.

Each output ORs the conditions mapped to it. The assertion of that result waits out a programmable delay, counted in enabled ticks. Deassertion takes effect on the next clock edge. The asserted state then passes through a polarity bit and an open-drain or push-pull driver stage. The default configuration is active low and open drain, so several supervisors can share one wired-OR line. All configuration arrives as static parallel inputs.

Top module: `sup_fault_router`

## Requirements
- R1: Condition index i = 0..5 is the over-voltage flag of rail i, and index 6+i is its under-voltage flag. Bit `j*16+i` of `map_i` routes condition i to output j.
- R2: A pin whose 2-bit role code is 0 (auxiliary) raises condition 12+k while `gpi_i[k] ^ gpi_pol_i[k]` is 1.
- R3: A pin whose role code is 1 (margin) and which is driven low suppresses every over-voltage and under-voltage condition.
- R4: A pin whose role code is 2 (UV disable) and which is driven low suppresses only the under-voltage conditions. Over-voltage conditions still propagate.
- R5: A pin whose role code is 3 (manual reset) raises condition 14+k while it is low.
- R6: An output's request is the OR of the conditions mapped to it. An output with no active mapped condition never asserts.
- R7: The 3-bit delay code c gives a hold count of 0 for c=0 and BASE_TICKS<<(c-1) otherwise. The output asserts on the first edge at which the tick counter equals that count. The counter advances only on edges where `tick_i` is high and the request holds.
- R8: An output deasserts on the first clock edge after its request clears.
- R9: With polarity 0 an asserted output has pin level low. With polarity 1 the asserted level is high.
- R10: In open-drain mode (mode bit 0), `gpio_o` is always 0 and `gpio_oe_o` is high only when the level is low. In push-pull mode (mode bit 1), `gpio_oe_o` is 1 and `gpio_o` carries the level.
- R11: After reset every output is deasserted. With the default polarity 0 and open-drain mode, the line is released (`gpio_oe_o` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Delay time-base enable |
| ov_i | input | 6 | Over-voltage flags per rail |
| uv_i | input | 6 | Under-voltage flags per rail |
| gpi_i | input | 2 | General-purpose input pin levels |
| gpi_mode_i | input | 4 | Role code per pin, 2 bits each |
| gpi_pol_i | input | 2 | Auxiliary comparator polarity per pin |
| map_i | input | 48 | Condition mapping, 16 bits per output |
| dly_sel_i | input | 9 | Delay code per output, 3 bits each |
| out_pol_i | input | 3 | Asserted level per output |
| out_mode_i | input | 3 | 0 open drain, 1 push-pull |
| gpio_o | output | 3 | Driven pin value |
| gpio_oe_o | output | 3 | Pin drive enable |

## Verification
The assertions assume that the configuration inputs stay constant while a fault request is pending. They also assume that the comparator and pin flags are already synchronous to `clk_i`. The bench changes inputs only on falling edges. Before it reprograms any configuration, it clears every fault and waits two edges, so each delay counter starts from zero. The timing checks hold `tick_i` high, so the count of edges to assertion follows directly from the delay code.

// File: rtl/sup_route_pkg.sv
package sup_route_pkg;
  localparam int unsigned NUM_CH  = 6;
  localparam int unsigned NUM_GPI = 2;
  localparam int unsigned NUM_OUT = 3;
  localparam int unsigned DLY_W   = 3;

  typedef enum logic [1:0] {
    GPI_AUX    = 2'd0,
    GPI_MARGIN = 2'd1,
    GPI_UVDIS  = 2'd2,
    GPI_MRST   = 2'd3
  } gpi_mode_e;
endpackage

// File: rtl/sup_cond_mask.sv
module sup_cond_mask
  import sup_route_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned N_GPI  = NUM_GPI,
  localparam int unsigned N_COND = 2*N_CH + 2*N_GPI
) (
  input  logic [N_CH-1:0]    ov_i,
  input  logic [N_CH-1:0]    uv_i,
  input  logic [N_GPI-1:0]   gpi_i,
  input  logic [2*N_GPI-1:0] gpi_mode_i,
  input  logic [N_GPI-1:0]   gpi_pol_i,
  output logic [N_COND-1:0]  cond_o
);
  logic [N_GPI-1:0] aux_c, mr_c, marg_c, uvd_c;
  logic             marg_act, uvd_act;

  for (genvar k = 0; k < N_GPI; k++) begin : g_gpi
    gpi_mode_e md;
    assign md        = gpi_mode_e'(gpi_mode_i[2*k +: 2]);
    assign aux_c[k]  = (md == GPI_AUX) && (gpi_i[k] ^ gpi_pol_i[k]);
    assign mr_c[k]   = (md == GPI_MRST) && !gpi_i[k];
    assign marg_c[k] = (md == GPI_MARGIN) && !gpi_i[k];
    assign uvd_c[k]  = (md == GPI_UVDIS) && !gpi_i[k];
  end

  assign marg_act = |marg_c;
  assign uvd_act  = |uvd_c;

  // margin masks OV and UV, UV-disable masks UV only
  assign cond_o = {mr_c, aux_c,
                   uv_i & {N_CH{!(marg_act || uvd_act)}},
                   ov_i & {N_CH{!marg_act}}};
endmodule

// File: rtl/sup_assert_dly.sv
module sup_assert_dly #(
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned DLY_W      = 3,
  localparam int unsigned MAX_CNT   = BASE_TICKS << ((1 << DLY_W) - 2),
  localparam int unsigned CNT_W     = $clog2(MAX_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic             asrt_o
);
  logic [CNT_W-1:0] cnt_q, target;

  always_comb begin
    if (sel_i == '0) target = '0;
    else             target = CNT_W'(BASE_TICKS) << (sel_i - DLY_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      asrt_o <= 1'b0;
    end else if (!req_i) begin
      cnt_q  <= '0;
      asrt_o <= 1'b0;
    end else if (cnt_q == target) begin
      asrt_o <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sup_pin_drv.sv
module sup_pin_drv (
  input  logic asrt_i,
  input  logic pol_i,
  input  logic mode_i,
  output logic pin_o,
  output logic oe_o
);
  logic level;
  assign level = asrt_i ? pol_i : !pol_i;
  assign pin_o = mode_i ? level : 1'b0;
  assign oe_o  = mode_i ? 1'b1 : !level;
endmodule

// File: rtl/sup_fault_router.sv
module sup_fault_router
  import sup_route_pkg::*;
#(
  parameter int unsigned N_CH       = NUM_CH,
  parameter int unsigned N_GPI      = NUM_GPI,
  parameter int unsigned N_OUT      = NUM_OUT,
  parameter int unsigned D_W        = DLY_W,
  parameter int unsigned BASE_TICKS = 4,
  localparam int unsigned N_COND    = 2*N_CH + 2*N_GPI
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [N_CH-1:0]          ov_i,
  input  logic [N_CH-1:0]          uv_i,
  input  logic [N_GPI-1:0]         gpi_i,
  input  logic [2*N_GPI-1:0]       gpi_mode_i,
  input  logic [N_GPI-1:0]         gpi_pol_i,
  input  logic [N_OUT*N_COND-1:0]  map_i,
  input  logic [N_OUT*D_W-1:0]     dly_sel_i,
  input  logic [N_OUT-1:0]         out_pol_i,
  input  logic [N_OUT-1:0]         out_mode_i,
  output logic [N_OUT-1:0]         gpio_o,
  output logic [N_OUT-1:0]         gpio_oe_o
);
  logic [N_COND-1:0] cond;
  logic [N_OUT-1:0]  req, asrt;

  sup_cond_mask #(.N_CH(N_CH), .N_GPI(N_GPI)) u_mask (
    .ov_i, .uv_i, .gpi_i, .gpi_mode_i, .gpi_pol_i, .cond_o(cond)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign req[j] = |(map_i[j*N_COND +: N_COND] & cond);

    sup_assert_dly #(.BASE_TICKS(BASE_TICKS), .DLY_W(D_W)) u_dly (
      .clk_i, .rst_ni, .tick_i,
      .req_i (req[j]),
      .sel_i (dly_sel_i[j*D_W +: D_W]),
      .asrt_o(asrt[j])
    );

    sup_pin_drv u_drv (
      .asrt_i(asrt[j]),
      .pol_i (out_pol_i[j]),
      .mode_i(out_mode_i[j]),
      .pin_o (gpio_o[j]),
      .oe_o  (gpio_oe_o[j])
    );
  end
endmodule

// File: rtl/sup_fault_router_chk.sv
module sup_fault_router_chk #(
  parameter int unsigned N_CH   = 6,
  parameter int unsigned N_GPI  = 2,
  parameter int unsigned N_OUT  = 3,
  parameter int unsigned N_COND = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_CH-1:0]         ov_i,
  input logic [N_GPI-1:0]        gpi_i,
  input logic [2*N_GPI-1:0]      gpi_mode_i,
  input logic [N_OUT*N_COND-1:0] map_i,
  input logic [N_OUT-1:0]        out_mode_i,
  input logic [N_OUT-1:0]        gpio_o,
  input logic [N_OUT-1:0]        gpio_oe_o,
  input logic [N_COND-1:0]       cond,
  input logic [N_OUT-1:0]        asrt
);
  logic marg, uvd;
  always_comb begin
    marg = 1'b0;
    uvd  = 1'b0;
    for (int k = 0; k < N_GPI; k++) begin
      if (gpi_mode_i[2*k +: 2] == 2'd1 && !gpi_i[k]) marg = 1'b1;
      if (gpi_mode_i[2*k +: 2] == 2'd2 && !gpi_i[k]) uvd  = 1'b1;
    end
  end

  // R3
  margin_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marg |-> (cond[2*N_CH-1:0] == '0));

  // R4
  uvdis_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uvd && !marg) |-> (cond[2*N_CH-1:N_CH] == '0 && cond[N_CH-1:0] == ov_i));

  for (genvar j = 0; j < N_OUT; j++) begin : g_chk
    // R8
    clear_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (~|(map_i[j*N_COND +: N_COND] & cond)) |=> !asrt[j]);

    // R7
    rise_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(asrt[j]) |-> $past(|(map_i[j*N_COND +: N_COND] & cond)));

    // R10
    od_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_mode_i[j] |-> !gpio_o[j]);

    // R10
    pp_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_mode_i[j] |-> gpio_oe_o[j]);
  end
endmodule

bind sup_fault_router sup_fault_router_chk #(
  .N_CH(N_CH), .N_GPI(N_GPI), .N_OUT(N_OUT), .N_COND(N_COND)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ov_i(ov_i), .gpi_i(gpi_i),
  .gpi_mode_i(gpi_mode_i), .map_i(map_i), .out_mode_i(out_mode_i),
  .gpio_o(gpio_o), .gpio_oe_o(gpio_oe_o), .cond(cond), .asrt(asrt)
);

// File: tb/sup_fault_router_tb_top.sv
module sup_fault_router_tb_top;
  localparam int BASE = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1;
  logic [5:0]  ov_i = '0, uv_i = '0;
  logic [1:0]  gpi_i = 2'b00, gpi_pol_i = 2'b00;
  logic [3:0]  gpi_mode_i = '0;
  logic [47:0] map_i = '0;
  logic [8:0]  dly_sel_i = '0;
  logic [2:0]  out_pol_i = '0, out_mode_i = '0;
  logic [2:0]  gpio_o, gpio_oe_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = !clk_i;

  sup_fault_router dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    ov_i = '0; uv_i = '0; gpi_i = 2'b00; gpi_mode_i = '0; gpi_pol_i = '0;
    map_i = '0; dly_sel_i = '0; out_pol_i = '0; out_mode_i = '0;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 oe", 32'(gpio_oe_o), 0);
    chk("R11 pin", 32'(gpio_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 post", 32'(gpio_oe_o), 0);

    // R1 R6: each rail flag routed to one output, others must stay idle
    for (int i = 0; i < 12; i++) begin
      idle();
      if (i < 6) ov_i[i] = 1'b1; else uv_i[i-6] = 1'b1;
      map_i[(i%3)*16 + i] = 1'b1;
      @(negedge clk_i);
      chk("R1 route", 32'(gpio_oe_o), 32'(1 << (i%3)));
      map_i[(i%3)*16 + ((i+1)%12)] = 1'b1;
      map_i[(i%3)*16 + i] = 1'b0;
      @(negedge clk_i);
      chk("R6 unmapped", 32'(gpio_oe_o), 0);
    end

    // R2 auxiliary comparator polarity
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 2; p++)
        for (int v = 0; v < 2; v++) begin
          idle();
          gpi_i = 2'b11;
          gpi_i[k] = v[0]; gpi_pol_i[k] = p[0];
          map_i = {3{16'(1 << (12+k))}};
          @(negedge clk_i);
          chk("R2 aux", 32'(gpio_oe_o), (v ^ p) ? 3 'b111 : 0);
        end

    // R3 R4 masking sweep on pin 0, pin 1 auxiliary and inactive
    for (int m = 1; m < 3; m++)
      for (int v = 0; v < 2; v++)
        for (int f = 0; f < 2; f++) begin
          idle();
          gpi_mode_i = 4'(m); gpi_i = {1'b0, v[0]};
          if (f == 0) ov_i = 6'h21; else uv_i = 6'h12;
          map_i[15:0] = 16'hffff;
          @(negedge clk_i);
          if (m == 1)
            chk("R3 margin", 32'(gpio_oe_o[0]), (v == 1) ? 1 : 0);
          else
            chk("R4 uvdis", 32'(gpio_oe_o[0]), (v == 1 || f == 0) ? 1 : 0);
        end

    // R5 manual reset
    for (int k = 0; k < 2; k++)
      for (int v = 0; v < 2; v++) begin
        idle();
        gpi_mode_i = 4'hf; gpi_i = 2'b11; gpi_i[k] = v[0];
        map_i[16 +: 16] = 16'(1 << (14+k));
        @(negedge clk_i);
        chk("R5 mrst", 32'(gpio_oe_o), (v == 0) ? 3'b010 : 0);
      end

    // R9 R10 polarity and drive mode
    for (int p = 0; p < 2; p++)
      for (int md = 0; md < 2; md++)
        for (int a = 0; a < 2; a++) begin
          idle();
          out_pol_i = {3{p[0]}}; out_mode_i = {3{md[0]}};
          ov_i[0] = a[0]; map_i[2*16] = 1'b1;
          @(negedge clk_i);
          begin
            logic lvl;
            lvl = a[0] ? p[0] : !p[0];
            chk("R9 level", 32'(md ? gpio_o[2] : !gpio_oe_o[2]), 32'(lvl));
            chk("R10 pin", 32'(gpio_o[2]), md ? 32'(lvl) : 0);
            chk("R10 oe", 32'(gpio_oe_o[2]), md ? 1 : 32'(!lvl));
          end
        end

    // R7 R8 delay per code
    for (int c = 0; c < 4; c++) begin
      int tgt;
      tgt = (c == 0) ? 0 : BASE << (c - 1);
      idle();
      dly_sel_i[2:0] = 3'(c); map_i[0] = 1'b1; ov_i[0] = 1'b1;
      if (tgt > 0) begin
        repeat (tgt) @(negedge clk_i);
        chk("R7 early", 32'(gpio_oe_o[0]), 0);
      end
      @(negedge clk_i);
      chk("R7 asserted", 32'(gpio_oe_o[0]), 1);
      ov_i[0] = 1'b0;
      @(negedge clk_i);
      chk("R8 release", 32'(gpio_oe_o[0]), 0);
    end

    // R7 tick gating and counter restart after a short glitch
    idle();
    dly_sel_i[2:0] = 3'd2; map_i[0] = 1'b1; ov_i[0] = 1'b1; tick_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R7 tick hold", 32'(gpio_oe_o[0]), 0);
    tick_i = 1'b1;
    repeat (5) @(negedge clk_i);
    ov_i[0] = 1'b0;
    @(negedge clk_i);
    ov_i[0] = 1'b1;
    repeat (8) @(negedge clk_i);
    chk("R7 restart", 32'(gpio_oe_o[0]), 0);
    @(negedge clk_i);
    chk("R7 restart done", 32'(gpio_oe_o[0]), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule